// File: doc/BRIEF.md
# Interrupt Source Priority Controller

This block sits between a set of level-sensitive external interrupt lines and an interrupt presenter. Each source has one register, and that register holds only the source's priority. Every cycle the block looks at all sources that are asserting and not masked. It picks the most favoured one and sends the presenter a single registered request. The request carries the source index and the priority widened to 8 bits.

The priority field is narrower than the architected 8 bits. The parameter `PRIO_BITS` sets its width, and the default is 3. Writing ones to every implemented bit masks the source, and a masked source reads back as 0xFF. Any smaller value is used as the priority unchanged. A read-only configuration register at word address 0 reports the implemented width to software. Source `i` lives at word address `i+1`. Software uses a simple 32-bit register bus, and read data is returned one cycle after the read request.

Top module: `irq_src_ctrl`

## Requirements
- R1: After reset every source is masked: `req_valid` is 0 and each source register reads 0xFF.
- R2: A write to source register `i` (word address `i+1`) keeps only bits `[PRIO_BITS-1:0]` of `bus_wdata`. An unmasked value reads back zero-extended in bits [7:0], with bits [31:8] zero.
- R3: A write whose implemented bits are all ones masks the source. The register then reads 0xFF, and the source never raises a request.
- R4: Word address 0 reads `PRIO_BITS` in bits [7:0] with zero above, and writes to it have no effect.
- R5: Among pending unmasked sources, the one with the numerically lowest priority wins.
- R6: When pending unmasked sources share the winning priority, the lowest source index wins.
- R7: `req_valid` is 1 exactly when, in the previous cycle, at least one source had `src_in` high and was unmasked.
- R8: `req_src` gives the winner's index, and `req_prio` gives its priority zero-extended to 8 bits.
- R9: The request is registered: a change on `src_in` or a register write shows on the request outputs after exactly one further rising edge.
- R10: A read returns data on `bus_rdata` in the cycle after the request. Addresses above `NUM_SRC` read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| src_in | input | NUM_SRC | Level-sensitive interrupt lines |
| req_valid | output | 1 | Request to the presenter |
| req_src | output | SRC_W | Index of the winning source |
| req_prio | output | 8 | Winner's priority, zero-extended |

## Verification
The checker tests every cycle that the request appears exactly when an unmasked source was pending. For each pending unmasked source, it tests that no source with a less favoured priority and no higher index of equal priority won. It also tests that the reported priority is never the masked code, and that reads of the configuration and unmapped addresses return the fixed values. Some behaviours only the bench's scenarios can show. These are truncation of written values, the 0xFF readback of masked sources, and the exact one-edge latency of the request.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;
    localparam int ARCH_PRIO_W = 8;
    localparam logic [ARCH_PRIO_W-1:0] PRIO_MASKED = 8'hFF;
    localparam int CFG_ADDR = 0;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } bus_op_e;

    function automatic bus_op_e decode_op(input logic en, input logic we);
        if (!en) return OP_IDLE;
        return we ? OP_WRITE : OP_READ;
    endfunction
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
    import irq_src_pkg::*;
#(
    parameter int NUM_SRC   = 16,
    parameter int PRIO_BITS = 3,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_en,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [PRIO_BITS-1:0] prio_q [NUM_SRC]
);
    localparam logic [PRIO_BITS-1:0] ALL1 = {PRIO_BITS{1'b1}};

    bus_op_e     op;
    logic [31:0] rd_d;

    assign op = decode_op(bus_en, bus_we);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst)
                prio_q[g] <= ALL1;
            else if (op == OP_WRITE && bus_addr == ADDR_W'(g + 1))
                prio_q[g] <= bus_wdata[PRIO_BITS-1:0];
        end
    end

    always_comb begin
        rd_d = '0;
        if (bus_addr == ADDR_W'(CFG_ADDR))
            rd_d[7:0] = 8'(PRIO_BITS);
        for (int i = 0; i < NUM_SRC; i++) begin
            if (bus_addr == ADDR_W'(i + 1)) begin
                if (prio_q[i] == ALL1) rd_d[7:0] = PRIO_MASKED;
                else                   rd_d[PRIO_BITS-1:0] = prio_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                 bus_rdata <= '0;
        else if (op == OP_READ)  bus_rdata <= rd_d;
    end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int NUM_SRC   = 16,
    parameter int PRIO_BITS = 3,
    parameter int SRC_W     = 4
) (
    input  logic [NUM_SRC-1:0]   src_in,
    input  logic [PRIO_BITS-1:0] prio_q [NUM_SRC],
    output logic                 found,
    output logic [SRC_W-1:0]     best_idx,
    output logic [PRIO_BITS-1:0] best_prio
);
    localparam logic [PRIO_BITS-1:0] ALL1 = {PRIO_BITS{1'b1}};

    always_comb begin
        found     = 1'b0;
        best_idx  = '0;
        best_prio = ALL1;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (src_in[i] && prio_q[i] != ALL1 &&
                (!found || prio_q[i] < best_prio)) begin
                found     = 1'b1;
                best_idx  = SRC_W'(i);
                best_prio = prio_q[i];
            end
        end
    end
endmodule

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl
    import irq_src_pkg::*;
#(
    parameter int NUM_SRC   = 16,
    parameter int PRIO_BITS = 3,
    parameter int ADDR_W    = 8,
    localparam int SRC_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_en,
    input  logic                   bus_we,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    input  logic [NUM_SRC-1:0]     src_in,
    output logic                   req_valid,
    output logic [SRC_W-1:0]       req_src,
    output logic [ARCH_PRIO_W-1:0] req_prio
);
    logic [PRIO_BITS-1:0]   prio_q [NUM_SRC];
    logic                   pick_found;
    logic [SRC_W-1:0]       pick_idx;
    logic [PRIO_BITS-1:0]   pick_prio;
    logic [ARCH_PRIO_W-1:0] prio_wide;

    irq_prio_regs #(.NUM_SRC(NUM_SRC), .PRIO_BITS(PRIO_BITS), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .prio_q(prio_q)
    );

    irq_pick #(.NUM_SRC(NUM_SRC), .PRIO_BITS(PRIO_BITS), .SRC_W(SRC_W)) u_pick (
        .src_in(src_in), .prio_q(prio_q), .found(pick_found),
        .best_idx(pick_idx), .best_prio(pick_prio)
    );

    always_comb begin
        prio_wide = '0;
        prio_wide[PRIO_BITS-1:0] = pick_prio;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_valid <= 1'b0;
            req_src   <= '0;
            req_prio  <= '0;
        end else begin
            req_valid <= pick_found;
            req_src   <= pick_found ? pick_idx  : '0;
            req_prio  <= pick_found ? prio_wide : '0;
        end
    end
endmodule

// File: rtl/irq_src_chk.sv
module irq_src_chk #(
    parameter int NUM_SRC   = 16,
    parameter int PRIO_BITS = 3,
    parameter int ADDR_W    = 8,
    parameter int SRC_W     = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_en,
    input logic                 bus_we,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [31:0]          bus_rdata,
    input logic [NUM_SRC-1:0]   src_in,
    input logic [PRIO_BITS-1:0] prio_q [NUM_SRC],
    input logic                 req_valid,
    input logic [SRC_W-1:0]     req_src,
    input logic [7:0]           req_prio
);
    localparam logic [PRIO_BITS-1:0] ALL1 = {PRIO_BITS{1'b1}};
    localparam logic [7:0] ALL1_W = 8'(ALL1);

    logic [NUM_SRC-1:0] pend;
    always_comb
        for (int i = 0; i < NUM_SRC; i++)
            pend[i] = src_in[i] && (prio_q[i] != ALL1);

    a_r1_reset_clears_req: assert property (@(posedge clk)
        rst |=> !req_valid);

    a_r7_valid_iff_pending: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (req_valid == $past(|pend)));

    a_r8_prio_never_masked: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_prio < ALL1_W));

    a_r4_cfg_read: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(bus_en && !bus_we && bus_addr == '0))
        |-> (bus_rdata == 32'(PRIO_BITS)));

    a_r10_unmapped_read_zero: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(bus_en && !bus_we && int'(bus_addr) > NUM_SRC))
        |-> (bus_rdata == 32'd0));

    for (genvar j = 0; j < NUM_SRC; j++) begin : g_win
        // R5 and R6: no pending unmasked source beats the reported winner
        a_r5_r6_winner_best: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(pend[j])) |->
            (req_valid &&
             ((req_prio < 8'($past(prio_q[j]))) ||
              (req_prio == 8'($past(prio_q[j])) && int'(req_src) <= j))));
    end
endmodule

bind irq_src_ctrl irq_src_chk #(
    .NUM_SRC(NUM_SRC), .PRIO_BITS(PRIO_BITS), .ADDR_W(ADDR_W), .SRC_W(SRC_W)
) u_chk (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .src_in(src_in), .prio_q(prio_q),
    .req_valid(req_valid), .req_src(req_src), .req_prio(req_prio)
);

// File: tb/tb_irq_src_ctrl.sv
module tb_irq_src_ctrl;
    localparam int NUM_SRC = 16;
    localparam int PRIO_BITS = 3;
    localparam int ADDR_W = 8;
    localparam int SRC_W = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_en = 1'b0, bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NUM_SRC-1:0] src_in = '0;
    logic req_valid;
    logic [SRC_W-1:0] req_src;
    logic [7:0] req_prio;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    irq_src_ctrl #(.NUM_SRC(NUM_SRC), .PRIO_BITS(PRIO_BITS), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
        .req_valid(req_valid), .req_src(req_src), .req_prio(req_prio)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'(addr); bus_wdata = data;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input int addr, output logic [31:0] data);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = ADDR_W'(addr);
        @(negedge clk);
        bus_en = 1'b0;
        data = bus_rdata;
    endtask

    task automatic drive_src(input logic [NUM_SRC-1:0] v);
        @(negedge clk);
        src_in = v;
        @(negedge clk);
    endtask

    task automatic check_req(input string tag, input logic v, input int s, input int p);
        check({tag, " valid"}, 32'(req_valid), 32'(v));
        if (v) begin
            check({tag, " src"}, 32'(req_src), 32'(s));
            check({tag, " prio"}, 32'(req_prio), 32'(p));
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 reset req_valid", 32'(req_valid), 0);
        bus_rd(1, d);  check("R1 src0 masked", d, 32'hFF);
        bus_rd(16, d); check("R1 src15 masked", d, 32'hFF);
        drive_src('1);
        check("R1 R7 all pending but masked", 32'(req_valid), 0);
        drive_src('0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        bus_wr(3, 32'h0000_0015); bus_rd(3, d);
        check("R2 truncated to low bits", d, 32'h5);
        bus_wr(3, 32'h6); bus_rd(3, d);
        check("R2 plain value", d, 32'h6);
        bus_wr(3, 32'h7); bus_rd(3, d);
        check("R3 all ones reads FF", d, 32'hFF);
        bus_wr(3, 32'hFFFF_FFFF); bus_rd(3, d);
        check("R3 wide ones reads FF", d, 32'hFF);
        bus_wr(3, 32'h0); bus_rd(3, d);
        check("R2 zero priority", d, 32'h0);
    endtask

    task automatic t_cfg_unmapped();
        logic [31:0] d;
        bus_rd(0, d); check("R4 config width", d, 32'(PRIO_BITS));
        bus_wr(0, 32'h55); bus_rd(0, d);
        check("R4 config unchanged by write", d, 32'(PRIO_BITS));
        bus_wr(20, 32'h1); bus_rd(20, d);
        check("R10 unmapped reads zero", d, 32'h0);
        bus_rd(16, d); check("R10 src15 untouched", d, 32'hFF);
        bus_rd(3, d);  check("R10 src2 untouched", d, 32'h0);
    endtask

    task automatic t_select();
        bus_wr(4, 32'h4);   // src3 prio 4
        bus_wr(8, 32'h2);   // src7 prio 2
        bus_wr(10, 32'h6);  // src9 prio 6
        bus_wr(6, 32'h4);   // src5 prio 4
        bus_wr(3, 32'h7);   // src2 masked
        drive_src(16'h0288);
        check_req("R5 R8 lowest prio wins", 1, 7, 2);
        drive_src(16'h0208);
        check_req("R5 next best", 1, 3, 4);
        drive_src(16'h0228);
        check_req("R6 tie lowest index", 1, 3, 4);
        bus_wr(2, 32'h4);   // src1 prio 4
        drive_src(16'h022A);
        check_req("R6 tie new lower index", 1, 1, 4);
        bus_wr(2, 32'h7);   // mask src1
        @(negedge clk);
        check_req("R3 masked source dropped", 1, 3, 4);
        bus_wr(16, 32'h0);  // src15 prio 0
        drive_src(16'h822A);
        check_req("R5 R8 prio zero high index", 1, 15, 0);
        drive_src(16'h0004);
        check_req("R7 only masked pending", 0, 0, 0);
    endtask

    task automatic t_latency();
        @(negedge clk);
        src_in = 16'h0080;
        #1 check("R9 no change before edge", 32'(req_valid), 0);
        @(negedge clk);
        check_req("R9 one edge later", 1, 7, 2);
        src_in = '0;
        #1 check("R9 still held before edge", 32'(req_valid), 1);
        @(negedge clk);
        check("R9 cleared after edge", 32'(req_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_cfg_unmapped();
        t_select();
        t_latency();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule